// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave Front End

This block sits between a microcontroller's external memory bus and an on-chip byte array with its write-protection logic. The host shares one byte-wide lane between the low address byte and the data, and sends the upper address bits on separate pins. An address-latch strobe marks when the shared lane carries an address. The block samples every bus pin into the core clock domain through a short synchronizer chain. When the latch strobe falls, it captures the full address and the chip-select state.

After the address is captured, the host reads the array through either of two active-low strobes. One serves program fetches and the other serves data reads, so the same array is visible in both of the host's address spaces. A third active-low strobe performs a write. The block drives read data back onto the shared lane through a separate output-enable. When the write strobe rises, it sends the protection logic a one-cycle write pulse together with the address and data. Strobe patterns that the host must never produce are treated as no access at all.

Top module: `adbus_front`

## Requirements
- R1: When the synchronized latch strobe `ale` goes from 1 to 0, the array address `mem_addr` becomes `{a_hi, ad_in}` as sampled at that moment. `mem_addr` holds that value until the next such falling transition.
- R2: An access counts only if `ce_n` was 0 when `ale` fell. After a latch with `ce_n` at 1, no read drives the bus and no write pulse is produced, even if `ce_n` goes low later.
- R3: A program-fetch read is `fetch_n`=0 with `rd_n`=1 and `wr_n`=1. While it lasts, `ad_oe` is 1 and `ad_out` equals `mem_rdata` for the latched address.
- R4: A data read is `rd_n`=0 with `fetch_n`=1 and `wr_n`=1. It drives `ad_out` and `ad_oe` in the same way as R3.
- R5: A write is `wr_n`=0 with `rd_n`=1 and `fetch_n`=1. When `wr_n` then rises, `wr_pulse` is 1 for exactly one clock cycle. In that cycle `wr_addr` is the latched address and `wr_data` is the value on `ad_in` when `wr_n` rose.
- R6: While `ce_n`=1 and `ale`=0, `standby` is 1 and `ad_oe` is 0.
- R7: `ad_oe` is 0 whenever `ale` is 1, even if a read strobe is low.
- R8: Any pattern with two or more of `fetch_n`, `rd_n` and `wr_n` at 0 produces no read and no write pulse.
- R9: After reset, `ad_oe`=0, `wr_pulse`=0, `mem_addr`=0 and `standby`=1 while `ce_n`=1 and `ale`=0.
- R10: If `wr_n` rises in the same sampled cycle that `ale` falls, the write pulse carries the address latched before that fall, and `mem_addr` moves to the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch strobe; the address is captured when it falls |
| ce_n | input | 1 | Active-low chip select |
| fetch_n | input | 1 | Active-low program-fetch read strobe |
| rd_n | input | 1 | Active-low data read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Shared address/data lane, input side |
| ad_out | output | 8 | Shared lane, read data driven by the block |
| ad_oe | output | 1 | Output enable for `ad_out` |
| a_hi | input | 5 | Upper address bits |
| mem_addr | output | 13 | Latched address presented to the array read port |
| mem_rdata | input | 8 | Array read data for `mem_addr` |
| wr_pulse | output | 1 | One-cycle write request to the protection logic |
| wr_addr | output | 13 | Address belonging to `wr_pulse` |
| wr_data | output | 8 | Data belonging to `wr_pulse` |
| standby | output | 1 | Deselected idle state indicator |

## Verification
Two functions can fall in the same sampled cycle: completing a write and latching a new address. A late write strobe can rise on the very cycle the next latch strobe falls. The bench provokes this by raising the latch strobe while `wr_n` is still low, with a new upper address, and then releasing `wr_n` and dropping `ale` on the same clock edge. The scoreboard expects the pulse to carry the old address and the held data, and expects `mem_addr` to show the new address afterwards.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

    typedef struct packed {
        logic ale;
        logic ce_n;
        logic fetch_n;
        logic rd_n;
        logic wr_n;
    } strobes_t;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_FETCH,
        ACC_DREAD,
        ACC_WRITE,
        ACC_BAD
    } access_e;

    // Exactly one low strobe is a legal access; none low is idle.
    function automatic access_e classify(input logic f_n, input logic r_n, input logic w_n);
        case ({f_n, r_n, w_n})
            3'b111:  return ACC_IDLE;
            3'b011:  return ACC_FETCH;
            3'b101:  return ACC_DREAD;
            3'b110:  return ACC_WRITE;
            default: return ACC_BAD;
        endcase
    endfunction

endpackage

// File: rtl/adbus_sync.sv
module adbus_sync #(
    parameter int W = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/adbus_addr_latch.sv
module adbus_addr_latch #(
    parameter int DATA_W = 8,
    parameter int AHI_W = 5,
    localparam int ADDR_W = DATA_W + AHI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale_s,
    input  logic              ce_n_s,
    input  logic [DATA_W-1:0] ad_s,
    input  logic [AHI_W-1:0]  ahi_s,
    output logic [ADDR_W-1:0] addr,
    output logic              sel
);
    logic ale_q;
    logic ale_fall;

    assign ale_fall = ale_q & ~ale_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q <= 1'b0;
            addr  <= '0;
            sel   <= 1'b0;
        end else begin
            ale_q <= ale_s;
            if (ale_fall) begin
                addr <= {ahi_s, ad_s};
                sel  <= ~ce_n_s;
            end
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(ale_fall) |-> $stable(addr)) else $error("address moved without latch"); // R1
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(ale_fall) |-> $stable(sel)) else $error("select moved without latch"); // R2
endmodule

// File: rtl/adbus_read_path.sv
module adbus_read_path
    import adbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  strobes_t          s,
    input  logic              sel,
    input  logic [DATA_W-1:0] mem_rdata,
    output access_e           acc,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              standby
);
    logic read_ok;

    assign acc     = classify(s.fetch_n, s.rd_n, s.wr_n);
    assign read_ok = sel & ~s.ale & ~s.ce_n & ((acc == ACC_FETCH) | (acc == ACC_DREAD));
    assign standby = s.ce_n & ~s.ale;

    always_ff @(posedge clk) begin
        if (rst) begin
            ad_oe  <= 1'b0;
            ad_out <= '0;
        end else begin
            ad_oe <= read_ok;
            if (read_ok) ad_out <= mem_rdata;
        end
    end

    AST_ALE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        s.ale |=> !ad_oe) else $error("bus driven during address phase"); // R7
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        standby |=> !ad_oe) else $error("bus driven in standby"); // R6
    AST_UNSEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !ad_oe) else $error("bus driven while deselected"); // R2
    AST_BAD_NO_READ: assert property (@(posedge clk) disable iff (rst)
        ($countones({~s.fetch_n, ~s.rd_n, ~s.wr_n}) > 1) |=> !ad_oe) else $error("read on illegal strobes"); // R8
endmodule

// File: rtl/adbus_write_gen.sv
module adbus_write_gen
    import adbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  access_e           acc,
    input  logic              sel,
    input  logic              ale_s,
    input  logic              ce_n_s,
    input  logic              wr_n_s,
    input  logic [DATA_W-1:0] ad_s,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic wr_q;
    logic armed;
    logic wr_rise;

    assign wr_rise = wr_n_s & ~wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b1;
            armed    <= 1'b0;
            wr_pulse <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_q     <= wr_n_s;
            wr_pulse <= 1'b0;
            if (acc == ACC_WRITE && sel && !ale_s && !ce_n_s)
                armed <= 1'b1;
            else if (acc == ACC_BAD)
                armed <= 1'b0;
            if (armed && wr_rise) begin
                wr_pulse <= 1'b1;
                wr_addr  <= addr;
                wr_data  <= ad_s;
                armed    <= 1'b0;
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse) else $error("write pulse longer than one cycle"); // R5
    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(wr_n_s)) else $error("write pulse without strobe release"); // R5
    AST_PULSE_SELECTED: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |-> $past(sel)) else $error("write pulse while deselected"); // R2
endmodule

// File: rtl/adbus_front.sv
module adbus_front
    import adbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AHI_W = 5,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = DATA_W + AHI_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic              ce_n,
    input  logic              fetch_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [AHI_W-1:0]  a_hi,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              standby
);
    localparam int SW = 5 + AHI_W + DATA_W;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 4'b1111, {AHI_W{1'b0}}, {DATA_W{1'b0}}};

    logic [SW-1:0]     sync_q;
    strobes_t          strb;
    logic [AHI_W-1:0]  ahi_s;
    logic [DATA_W-1:0] ad_s;
    logic              sel;
    access_e           acc;

    adbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ale, ce_n, fetch_n, rd_n, wr_n, a_hi, ad_in}),
        .q   (sync_q)
    );

    assign {strb, ahi_s, ad_s} = sync_q;

    adbus_addr_latch #(.DATA_W(DATA_W), .AHI_W(AHI_W)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .ale_s  (strb.ale),
        .ce_n_s (strb.ce_n),
        .ad_s   (ad_s),
        .ahi_s  (ahi_s),
        .addr   (mem_addr),
        .sel    (sel)
    );

    adbus_read_path #(.DATA_W(DATA_W)) u_read (
        .clk       (clk),
        .rst       (rst),
        .s         (strb),
        .sel       (sel),
        .mem_rdata (mem_rdata),
        .acc       (acc),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .standby   (standby)
    );

    adbus_write_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_write (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .sel      (sel),
        .ale_s    (strb.ale),
        .ce_n_s   (strb.ce_n),
        .wr_n_s   (strb.wr_n),
        .ad_s     (ad_s),
        .addr     (mem_addr),
        .wr_pulse (wr_pulse),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );
endmodule

// File: tb/adbus_front_tb_top.sv
module adbus_front_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ale = 1'b0, ce_n = 1'b1, fetch_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  ad_in = 8'h00;
    logic [4:0]  a_hi = 5'h00;
    logic [7:0]  ad_out, mem_rdata, wr_data;
    logic [12:0] mem_addr, wr_addr;
    logic        ad_oe, wr_pulse, standby;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [20:0] exp_q[$];
    int pulses_seen = 0;
    int pulses_exp = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] model(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b011};
    endfunction

    assign mem_rdata = model(mem_addr);

    adbus_front dut_i (
        .clk(clk), .rst(rst), .ale(ale), .ce_n(ce_n), .fetch_n(fetch_n),
        .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .a_hi(a_hi), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data), .standby(standby)
    );

    task automatic check(input bit ok, input string req, input logic [20:0] act, input logic [20:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Address phase: drive address, drop ALE, hold the lane while it is sampled.
    task automatic latch(input logic [12:0] a, input bit selected);
        @(negedge clk);
        ale = 1'b1; ad_in = a[7:0]; a_hi = a[12:8]; ce_n = !selected;
        idle(3);
        ale = 1'b0;
        idle(4);
        ad_in = 8'h5a;
    endtask

    task automatic do_read(input bit fetch, input logic [12:0] a, input bit exp_oe, input string req);
        if (fetch) fetch_n = 1'b0; else rd_n = 1'b0;
        idle(6);
        check(ad_oe === exp_oe, req, {20'b0, ad_oe}, {20'b0, exp_oe});
        if (exp_oe) check(ad_out === model(a), req, {13'b0, ad_out}, {13'b0, model(a)});
        fetch_n = 1'b1; rd_n = 1'b1;
        idle(4);
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d, input bit expect_pulse);
        wr_n = 1'b0; ad_in = d;
        idle(4);
        wr_n = 1'b1;
        if (expect_pulse) begin
            exp_q.push_back({a, d});
            pulses_exp++;
        end
        idle(4);
        ad_in = 8'hc3;
        idle(3);
    endtask

    // Monitor: every write pulse must match the head of the scoreboard (R5, R10).
    always @(negedge clk) begin
        if (!rst && wr_pulse) begin
            pulses_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected pulse", {wr_addr, wr_data}, 21'h0);
            end else begin
                logic [20:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} === e, "R5/R10 write item", {wr_addr, wr_data}, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(4);
        // R9 reset state
        check(ad_oe === 1'b0, "R9 oe", {20'b0, ad_oe}, 21'h0);
        check(wr_pulse === 1'b0, "R9 pulse", {20'b0, wr_pulse}, 21'h0);
        check(mem_addr === 13'h0, "R9 addr", {8'b0, mem_addr}, 21'h0);
        check(standby === 1'b1, "R9 standby", {20'b0, standby}, 21'h1);

        // R1 address capture, R3 fetch read
        latch(13'h1a5c, 1'b1);
        check(mem_addr === 13'h1a5c, "R1 latch", {8'b0, mem_addr}, {8'b0, 13'h1a5c});
        check(standby === 1'b0, "R6 selected not standby", {20'b0, standby}, 21'h0);
        do_read(1'b1, 13'h1a5c, 1'b1, "R3 fetch");
        // R4 data read at another address
        latch(13'h0733, 1'b1);
        check(mem_addr === 13'h0733, "R1 latch2", {8'b0, mem_addr}, {8'b0, 13'h0733});
        do_read(1'b0, 13'h0733, 1'b1, "R4 data read");

        // R5 write
        latch(13'h1f01, 1'b1);
        do_write(13'h1f01, 8'h9e, 1'b1);
        do_write(13'h1f01, 8'h21, 1'b1);

        // R2 deselected at latch, select asserted afterwards
        latch(13'h0444, 1'b0);
        ce_n = 1'b0;
        idle(3);
        do_read(1'b0, 13'h0444, 1'b0, "R2 unselected read");
        do_write(13'h0444, 8'h77, 1'b0);

        // R6 standby: selected latch, then CE_n released
        latch(13'h0210, 1'b1);
        ce_n = 1'b1;
        idle(3);
        check(standby === 1'b1, "R6 standby", {20'b0, standby}, 21'h1);
        do_read(1'b1, 13'h0210, 1'b0, "R6 standby read");
        ce_n = 1'b0;

        // R7 read strobe low while ALE high
        latch(13'h0abc, 1'b1);
        ale = 1'b1;
        do_read(1'b0, 13'h0abc, 1'b0, "R7 ale high");
        ale = 1'b0;
        idle(4);

        // R8 illegal combinations
        latch(13'h0c0d, 1'b1);
        fetch_n = 1'b0;
        do_read(1'b0, 13'h0c0d, 1'b0, "R8 fetch+rd");
        rd_n = 1'b0;
        do_write(13'h0c0d, 8'h44, 1'b0);
        rd_n = 1'b1;
        idle(4);
        check(ad_oe === 1'b0, "R8 rd+wr no read", {20'b0, ad_oe}, 21'h0);

        // R10 write release coincides with a new latch
        latch(13'h0155, 1'b1);
        wr_n = 1'b0; ad_in = 8'he7;
        idle(4);
        ale = 1'b1; a_hi = 5'h12;
        idle(3);
        ale = 1'b0; wr_n = 1'b1;
        exp_q.push_back({13'h0155, 8'he7});
        pulses_exp++;
        idle(6);
        check(mem_addr === {5'h12, 8'he7}, "R10 new addr", {8'b0, mem_addr}, {8'b0, 5'h12, 8'he7});

        idle(6);
        check(exp_q.size() == 0, "R5 missing pulse", 21'(exp_q.size()), 21'h0);
        check(pulses_seen == pulses_exp, "R5 pulse count", 21'(pulses_seen), 21'(pulses_exp));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule